// File: doc/BRIEF.md
# Compressed-Payload Burst Detector for IEC 60958 Subframes

This block sits behind an IEC 60958 receiver and decides, subframe by subframe, whether the stream carries linear PCM audio or a compressed bitstream. It receives each decoded subframe's audio sample field with a valid strobe and a tag saying whether the subframe belongs to channel A or channel B. It also receives the channel-status bit that marks the content as non-audio.

A burst is recognised when a run of at least four all-zero subframes is followed, on the next two accepted subframes, by the sync word 0xF872 and then the sync word 0x4E1F. At that point the block raises a one-cycle start pulse and sets a sticky detect flag. The flag stays up until a configurable number of accepted subframes go by without another sync pair. The channel-status bit raises the same flag directly. A downstream mute control can use the flag to silence the DAC path while non-audio content is present.

Top module: `nonpcm_burst_detect`

## Requirements
- R1: While rst_n is low, and in the cycle after it is released, burst_start and data_det are 0. A reset in the middle of a sync sequence discards the partial match.
- R2: A zero subframe is one whose whole sample field is 0. A sync pair is accepted only if at least four zero subframes come directly before the 0xF872 subframe. Three zeros are not enough.
- R3: The sync words are compared with sample bits [SAMPLE_W-1:SAMPLE_W-16], and the bits below them are ignored. The 0x4E1F subframe must be the first accepted subframe after the 0xF872 subframe. burst_start is high for exactly one cycle, the cycle after the 0x4E1F subframe is accepted.
- R4: The 0x4E1F subframe must carry the opposite channel tag from the 0xF872 subframe (sf_chan_b: 0 = channel A, 1 = channel B). Two sync words on the same channel are not a pair.
- R5: A non-zero subframe clears the zero-run count. A 0xF872 subframe followed by any word other than 0x4E1F produces no detection.
- R6: A zero run longer than four subframes still qualifies a following sync pair.
- R7: Cycles with sf_valid low neither advance nor break the zero run or a pending sync match.
- R8: data_det rises in the same cycle as burst_start. It stays high until HOLD_SF accepted subframes have followed without a new pair, and falls in the cycle after the last of them is accepted. A new pair restarts the count.
- R9: cs_nonpcm high makes data_det high from the next cycle on, whether or not a sync pair has been seen. With no hold count running, data_det falls the cycle after cs_nonpcm goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sf_valid | input | 1 | A subframe is presented this cycle |
| sf_chan_b | input | 1 | Channel tag: 0 = A, 1 = B |
| sf_sample | input | SAMPLE_W | Audio sample field of the subframe |
| cs_nonpcm | input | 1 | Channel-status bit marking non-audio content |
| burst_start | output | 1 | One-cycle pulse after a qualified sync pair |
| data_det | output | 1 | Compressed content present |

## Verification
A stuck or miscounted zero-run counter shows up at the ports within a few subframes: a three-zero preamble wrongly fires burst_start, or a legal preamble fails to fire it. A lost pending-match bit, or one that survives an idle cycle or a reset, changes burst_start on the very next accepted subframe. An error in the hold counter moves the falling edge of data_det by one or more accepted subframes. The bench therefore samples that edge exactly, both after a single pair and after a pair that restarts the count.

// File: rtl/nonpcm_pkg.sv
`timescale 1ns/1ps
package nonpcm_pkg;
  localparam int unsigned SYNC_W       = 16;
  localparam logic [SYNC_W-1:0] SYNC_FIRST  = 16'hF872;
  localparam logic [SYNC_W-1:0] SYNC_SECOND = 16'h4E1F;
  localparam int unsigned ZERO_RUN_MIN = 4;

  // one accepted subframe as seen by the matching logic
  typedef struct packed {
    logic              en;
    logic              chan_b;
    logic              is_zero;
    logic [SYNC_W-1:0] word;
  } sf_view_t;
endpackage

// File: rtl/nonpcm_zero_run.sv
`timescale 1ns/1ps
module nonpcm_zero_run #(
  parameter int unsigned RUN_MIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sf_en,
  input  logic sf_is_zero,
  input  logic clr,
  output logic run_ok
);
  localparam int unsigned CNT_W = $clog2(RUN_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_MIN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = sf_en | clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (sf_en) begin
      if (!sf_is_zero)          cnt_d = '0;
      else if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign run_ok = (cnt_q == CNT_MAX);
endmodule

// File: rtl/nonpcm_sync_match.sv
`timescale 1ns/1ps
module nonpcm_sync_match
  import nonpcm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  sf_view_t sf,
  input  logic     run_ok,
  output logic     hit
);
  logic pend_q, pend_d;
  logic pend_chan_q, pend_chan_d;

  always_comb begin
    pend_d      = pend_q;
    pend_chan_d = pend_chan_q;
    if (sf.en) begin
      pend_d      = run_ok && (sf.word == SYNC_FIRST);
      pend_chan_d = sf.chan_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_chan_q <= 1'b0;
    end else if (sf.en) begin
      pend_q      <= pend_d;
      pend_chan_q <= pend_chan_d;
    end
  end

  assign hit = sf.en && pend_q && (sf.word == SYNC_SECOND) &&
               (sf.chan_b != pend_chan_q);
endmodule

// File: rtl/nonpcm_hold_timer.sv
`timescale 1ns/1ps
module nonpcm_hold_timer #(
  parameter int unsigned HOLD_SF = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sf_en,
  input  logic hit,
  output logic active
);
  localparam int unsigned HOLD_W = $clog2(HOLD_SF + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_SF);

  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign cnt_en = hit | (sf_en & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (hit)                          cnt_d = HOLD_LOAD;
    else if (sf_en && cnt_q != '0)    cnt_d = cnt_q - HOLD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/nonpcm_burst_detect.sv
`timescale 1ns/1ps
module nonpcm_burst_detect
  import nonpcm_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned HOLD_SF  = 4096,
  parameter int unsigned RUN_MIN  = ZERO_RUN_MIN
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sf_valid,
  input  logic                sf_chan_b,
  input  logic [SAMPLE_W-1:0] sf_sample,
  input  logic                cs_nonpcm,
  output logic                burst_start,
  output logic                data_det
);
  localparam int unsigned WORD_LSB = SAMPLE_W - SYNC_W;

  sf_view_t sf;
  logic     run_ok, hit, hold_active;
  logic     start_q, start_d;
  logic     cs_q;

  assign sf.en      = sf_valid;
  assign sf.chan_b  = sf_chan_b;
  assign sf.is_zero = (sf_sample == '0);
  assign sf.word    = sf_sample[SAMPLE_W-1:WORD_LSB];

  nonpcm_zero_run #(.RUN_MIN(RUN_MIN)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .sf_en      (sf.en),
    .sf_is_zero (sf.is_zero),
    .clr        (hit),
    .run_ok     (run_ok)
  );

  nonpcm_sync_match u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .sf     (sf),
    .run_ok (run_ok),
    .hit    (hit)
  );

  nonpcm_hold_timer #(.HOLD_SF(HOLD_SF)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .sf_en  (sf.en),
    .hit    (hit),
    .active (hold_active)
  );

  assign start_d = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      cs_q    <= 1'b0;
    end else begin
      start_q <= start_d;
      cs_q    <= cs_nonpcm;
    end
  end

  assign burst_start = start_q;
  assign data_det    = hold_active | cs_q;
endmodule

// File: rtl/nonpcm_burst_detect_chk.sv
`timescale 1ns/1ps
module nonpcm_burst_detect_chk #(
  parameter int unsigned SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sf_valid,
  input logic                sf_chan_b,
  input logic [SAMPLE_W-1:0] sf_sample,
  input logic                cs_nonpcm,
  input logic                burst_start,
  input logic                data_det
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!burst_start && !data_det));

  assert_start_follows_second_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> ($past(sf_valid) && $past(sf_sample[SAMPLE_W-1 -: 16]) == 16'h4E1F));

  assert_start_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> !burst_start);

  assert_idle_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_valid |=> !burst_start);

  assert_start_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> data_det);

  assert_cs_raises_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_nonpcm |=> data_det);

  assert_fall_needs_cs_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_det) |-> !$past(cs_nonpcm));
endmodule

bind nonpcm_burst_detect nonpcm_burst_detect_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sf_valid    (sf_valid),
  .sf_chan_b   (sf_chan_b),
  .sf_sample   (sf_sample),
  .cs_nonpcm   (cs_nonpcm),
  .burst_start (burst_start),
  .data_det    (data_det)
);

// File: tb/sim_nonpcm_burst_detect.sv
`timescale 1ns/1ps
module sim_nonpcm_burst_detect;
  localparam int unsigned SW   = 24;
  localparam int unsigned HOLD = 6;

  typedef struct packed {
    logic        v;
    logic        ch;
    logic        cs;
    logic [23:0] s;
    logic        st;
    logic        det;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 52;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b0,4'd2},  // 0  R2 zero run
    '{1'b1,1'b1,1'b0,24'h000000,1'b0,1'b0,4'd2},
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b0,4'd2},
    '{1'b1,1'b1,1'b0,24'h000000,1'b0,1'b0,4'd2},
    '{1'b1,1'b0,1'b0,24'hF87200,1'b0,1'b0,4'd3},  // 4  first word
    '{1'b1,1'b1,1'b0,24'h4E1F00,1'b1,1'b1,4'd3},  // 5  R3 pair found
    '{1'b1,1'b0,1'b0,24'h000123,1'b0,1'b1,4'd8},  // 6  hold 5
    '{1'b0,1'b0,1'b0,24'h000000,1'b0,1'b1,4'd7},  // 7  idle, R7
    '{1'b1,1'b1,1'b0,24'h000001,1'b0,1'b1,4'd8},  // 8  hold 4
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b1,4'd8},  // 9  hold 3
    '{1'b1,1'b1,1'b0,24'h000000,1'b0,1'b1,4'd8},  // 10 hold 2
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b1,4'd8},  // 11 hold 1
    '{1'b1,1'b1,1'b0,24'hF87200,1'b0,1'b0,4'd8},  // 12 R8 fall; only 3 zeros
    '{1'b1,1'b0,1'b0,24'h4E1F00,1'b0,1'b0,4'd2},  // 13 R2 rejected
    '{1'b1,1'b1,1'b0,24'h000000,1'b0,1'b0,4'd5},
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b0,4'd5},
    '{1'b1,1'b1,1'b0,24'h000000,1'b0,1'b0,4'd5},
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b0,4'd5},
    '{1'b1,1'b0,1'b0,24'hF87200,1'b0,1'b0,4'd5},  // 18
    '{1'b1,1'b1,1'b0,24'h123456,1'b0,1'b0,4'd5},  // 19 R5 wrong second
    '{1'b1,1'b0,1'b0,24'h4E1F00,1'b0,1'b0,4'd5},  // 20 R5 too late
    '{1'b1,1'b1,1'b0,24'h000000,1'b0,1'b0,4'd4},
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b0,4'd4},
    '{1'b1,1'b1,1'b0,24'h000000,1'b0,1'b0,4'd4},
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b0,4'd4},
    '{1'b1,1'b1,1'b0,24'hF87200,1'b0,1'b0,4'd4},  // 25 on B
    '{1'b1,1'b1,1'b0,24'h4E1F00,1'b0,1'b0,4'd4},  // 26 R4 same tag
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b0,4'd6},  // 27 R6 six zeros
    '{1'b1,1'b1,1'b0,24'h000000,1'b0,1'b0,4'd6},
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b0,4'd6},
    '{1'b1,1'b1,1'b0,24'h000000,1'b0,1'b0,4'd6},
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b0,4'd6},
    '{1'b1,1'b1,1'b0,24'h000000,1'b0,1'b0,4'd6},
    '{1'b0,1'b0,1'b0,24'h000000,1'b0,1'b0,4'd7},  // 33 idle
    '{1'b1,1'b0,1'b0,24'hF87255,1'b0,1'b0,4'd3},  // 34 low bits ignored
    '{1'b0,1'b0,1'b0,24'h000000,1'b0,1'b0,4'd7},  // 35 idle keeps pending
    '{1'b1,1'b1,1'b0,24'h4E1FAA,1'b1,1'b1,4'd6},  // 36 R6 R7 R3 pair
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b1,4'd8},  // 37 hold 5
    '{1'b1,1'b1,1'b0,24'h000000,1'b0,1'b1,4'd8},
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b1,4'd8},
    '{1'b1,1'b1,1'b0,24'h000000,1'b0,1'b1,4'd8},  // 40 hold 2
    '{1'b1,1'b0,1'b0,24'hF87200,1'b0,1'b1,4'd8},  // 41 hold 1
    '{1'b1,1'b1,1'b0,24'h4E1F00,1'b1,1'b1,4'd8},  // 42 R8 restart
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b1,4'd8},
    '{1'b1,1'b1,1'b0,24'h000000,1'b0,1'b1,4'd8},
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b1,4'd8},
    '{1'b1,1'b1,1'b0,24'h000000,1'b0,1'b1,4'd8},
    '{1'b1,1'b0,1'b0,24'h000000,1'b0,1'b1,4'd8},  // 47 hold 1
    '{1'b1,1'b1,1'b0,24'h000000,1'b0,1'b0,4'd8},  // 48 R8 fall
    '{1'b0,1'b0,1'b1,24'h000000,1'b0,1'b1,4'd9},  // 49 R9 status bit
    '{1'b1,1'b0,1'b1,24'h000000,1'b0,1'b1,4'd9},
    '{1'b0,1'b0,1'b0,24'h000000,1'b0,1'b0,4'd9}   // 51 R9 drop
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sf_valid, sf_chan_b, cs_nonpcm;
  logic [SW-1:0] sf_sample;
  logic          burst_start, data_det;
  int            total = 0;
  int            bad   = 0;

  always #10 clk = ~clk;

  nonpcm_burst_detect #(.SAMPLE_W(SW), .HOLD_SF(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_chan_b(sf_chan_b),
    .sf_sample(sf_sample), .cs_nonpcm(cs_nonpcm),
    .burst_start(burst_start), .data_det(data_det)
  );

  task automatic step(input logic v, input logic ch, input logic [SW-1:0] s, input logic cs);
    @(negedge clk);
    sf_valid = v; sf_chan_b = ch; sf_sample = s; cs_nonpcm = cs;
    @(posedge clk);
    #5;
  endtask

  task automatic check(input string tag, input logic st, input logic det);
    total++;
    if (burst_start !== st || data_det !== det) begin
      bad++;
      $display("FAIL %s: burst_start=%b data_det=%b expected %b %b", tag, burst_start, data_det, st, det);
    end
  endtask

  task automatic run_all();
    sf_valid = 0; sf_chan_b = 0; sf_sample = '0; cs_nonpcm = 0; rst_n = 0;
    #15;
    check("R1 in reset", 1'b0, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #5;
    check("R1 after release", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].v, TBL[i].ch, TBL[i].s, TBL[i].cs);
      check($sformatf("R%0d vec %0d", TBL[i].req, i), TBL[i].st, TBL[i].det);
    end

    // R1: a reset between the two sync words drops the pending match
    for (int k = 0; k < 4; k++) step(1'b1, k[0], '0, 1'b0);
    step(1'b1, 1'b0, 24'hF87200, 1'b0);
    @(negedge clk); rst_n = 0; sf_valid = 0;
    @(posedge clk); #5;
    check("R1 reset mid sync", 1'b0, 1'b0);
    @(negedge clk); rst_n = 1;
    step(1'b1, 1'b1, 24'h4E1F00, 1'b0);
    check("R1 pending cleared", 1'b0, 1'b0);

    // R3: a clean sequence after reset, then the pulse drops after one cycle
    for (int k = 0; k < 4; k++) step(1'b1, k[0], '0, 1'b0);
    step(1'b1, 1'b0, 24'hF87201, 1'b0);
    step(1'b1, 1'b1, 24'h4E1F02, 1'b0);
    check("R3 pair after reset", 1'b1, 1'b1);
    step(1'b0, 1'b0, '0, 1'b0);
    check("R3 single pulse", 1'b0, 1'b1);

    // R9: the status bit keeps the flag up after the hold count has run out
    step(1'b1, 1'b0, '0, 1'b1);
    for (int k = 0; k < HOLD; k++) step(1'b1, k[0], '0, 1'b1);
    check("R9 status holds flag", 1'b0, 1'b1);
    step(1'b0, 1'b0, '0, 1'b0);
    check("R9 flag drops", 1'b0, 1'b0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule